// File: doc/BRIEF.md
# Host Interrupt Status Controller

This block gathers a vector of event lines from device logic and turns them into latched status bits that a host inspects and clears through a small register port. Each status bit captures a rising edge of its event line. A mask vector decides which latched bits may drive the single level interrupt line toward the host, and a configuration bit chooses whether that line is active-high or active-low.

The host reaches everything through one generic port: a word address, a write enable with write data, and a read enable. Read data appears on the cycle after the read enable. The mask can be loaded whole or changed bit by bit through a set alias and a clear alias. Status can be read without disturbing it, or read and emptied in one access. It can also be cleared bit by bit by writing ones to an acknowledge register. An event that arrives in the same cycle as any clear is never lost.

Word offsets (bits above `NUM_SRC` in written data are ignored; unused read bits return 0): 0 mask (read/write), 1 mask-set (write only), 2 mask-clear (write only), 3 status peek (read only), 4 status take (read only, clears), 5 acknowledge (write only), 6 configuration (bit 0 = 1 selects an active-low interrupt line).

Top module: `hint_ctrl`

## Requirements
- R1: After reset the mask reads 0x0001, the status reads 0, the configuration reads 0 and the interrupt line is low.
- R2: A status bit is set on the cycle after its event line goes from 0 to 1, whether or not it is masked; an event line held high does not set the bit again after it is cleared.
- R3: A write to offset 0 loads the mask from write-data bits [NUM_SRC-1:0], and a read of offset 0 returns the mask zero-extended.
- R4: A write to offset 1 sets every mask bit written as 1 and leaves the mask bits written as 0 unchanged.
- R5: A write to offset 2 clears every mask bit written as 1 and leaves the mask bits written as 0 unchanged.
- R6: A read of offset 3 returns the status on the next cycle and leaves the status unchanged; when no read is requested the read data is 0.
- R7: A read of offset 4 returns the status on the next cycle and clears all status bits.
- R8: A write to offset 5 clears every status bit written as 1; bits written as 0 keep their state.
- R9: A status bit whose event rises in the same cycle as an acknowledge or a clearing read of that bit stays set.
- R10: The interrupt line is asserted exactly when some status bit has its mask bit at 0; configuration bit 0 at offset 6 selects the level: 0 means asserted high, 1 means asserted low.
- R11: Reads of write-only or unmapped offsets return 0, and writes to the read-only status offsets change neither status nor mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Event lines from device logic, synchronous to clk |
| addr_i | input | ADDR_W | Register word offset |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | DATA_W | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | DATA_W | Read data, valid the cycle after rd_en_i |
| irq_o | output | 1 | Level interrupt line to the host |

## Verification
The assertions take for granted that event lines are synchronous to clk and that a read and a write never share a cycle, so each cycle carries at most one register command. The stimulus drives every input at the falling edge, keeps read and write strobes one cycle long and never overlapping, and holds the event lines low through reset. Coincidences of an event edge with an acknowledge or a clearing read are produced deliberately by raising the event line in the same cycle as the strobe.

// File: rtl/hint_pkg.sv
package hint_pkg;

   // Register word offsets. The bench and host software decode these.
   typedef enum logic [2:0] {
      HREG_MASK = 3'd0,
      HREG_MSET = 3'd1,
      HREG_MCLR = 3'd2,
      HREG_PEEK = 3'd3,
      HREG_TAKE = 3'd4,
      HREG_ACK  = 3'd5,
      HREG_CFG  = 3'd6
   } hint_reg_e;

   localparam int unsigned HREG_AW_MIN = 3;

   // One-cycle strobes produced by the register decoder.
   typedef struct packed {
      logic mask_load;
      logic mask_set;
      logic mask_clr;
      logic ack;
      logic take;
   } hint_cmd_t;

endpackage

// File: rtl/hint_edge.sv
module hint_edge #(
   parameter int unsigned NUM_SRC = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   output logic [NUM_SRC-1:0] rise_o
);

   logic [NUM_SRC-1:0] src_q;

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) src_q[g] <= 1'b0;
         else        src_q[g] <= src_i[g];
      end
      assign rise_o[g] = src_i[g] & ~src_q[g];
   end

endmodule

// File: rtl/hint_status.sv
module hint_status #(
   parameter int unsigned NUM_SRC = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] rise_i,
   input  logic [NUM_SRC-1:0] ack_i,
   input  logic               take_i,
   output logic [NUM_SRC-1:0] stat_o
);

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
      logic drop;
      assign drop = take_i | ack_i[g];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stat_o[g] <= 1'b0;
         else        stat_o[g] <= rise_i[g] | (stat_o[g] & ~drop);
      end
   end

   AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_i != '0) |=> ((stat_o & $past(rise_i)) == $past(rise_i))); // R2 R9
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i != '0) |=> ((stat_o & $past(ack_i & ~rise_i)) == '0)); // R8
   AST_TAKE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |=> ((stat_o & ~$past(rise_i)) == '0)); // R7
   AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_i == '0 && ack_i == '0 && !take_i) |=> $stable(stat_o)); // R6

endmodule

// File: rtl/hint_mask.sv
module hint_mask #(
   parameter int unsigned           NUM_SRC  = 16,
   parameter logic [NUM_SRC-1:0]    MASK_RST = NUM_SRC'(1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_i,
   input  logic [NUM_SRC-1:0] set_i,
   input  logic [NUM_SRC-1:0] clr_i,
   input  logic [NUM_SRC-1:0] bits_i,
   output logic [NUM_SRC-1:0] mask_o
);

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       mask_o[g] <= MASK_RST[g];
         else if (load_i)  mask_o[g] <= bits_i[g];
         else if (set_i[g]) mask_o[g] <= 1'b1;
         else if (clr_i[g]) mask_o[g] <= 1'b0;
      end
   end

   AST_SET_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && set_i != '0) |=> ((mask_o & $past(set_i)) == $past(set_i))); // R4
   AST_CLR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && clr_i != '0) |=> ((mask_o & $past(clr_i)) == '0)); // R5
   AST_MASK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && set_i == '0 && clr_i == '0) |=> $stable(mask_o)); // R4 R5
   AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (mask_o == $past(bits_i))); // R3

endmodule

// File: rtl/hint_regif.sv
module hint_regif
   import hint_pkg::*;
#(
   parameter int unsigned NUM_SRC = 16,
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned DATA_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic               wr_en_i,
   input  logic [DATA_W-1:0]  wr_data_i,
   input  logic               rd_en_i,
   input  logic [NUM_SRC-1:0] stat_i,
   input  logic [NUM_SRC-1:0] mask_i,
   output hint_cmd_t          cmd_o,
   output logic [NUM_SRC-1:0] bits_o,
   output logic               pol_low_o,
   output logic [DATA_W-1:0]  rd_data_o
);

   logic unused_wr_data;
   logic [DATA_W-1:0] rd_mux;

   assign unused_wr_data = ^wr_data_i;
   assign bits_o = wr_data_i[NUM_SRC-1:0];

   function automatic logic hit(input logic [ADDR_W-1:0] a, input hint_reg_e r);
      return a == ADDR_W'(r);
   endfunction

   always_comb begin
      cmd_o           = '0;
      cmd_o.mask_load = wr_en_i && hit(addr_i, HREG_MASK);
      cmd_o.mask_set  = wr_en_i && hit(addr_i, HREG_MSET);
      cmd_o.mask_clr  = wr_en_i && hit(addr_i, HREG_MCLR);
      cmd_o.ack       = wr_en_i && hit(addr_i, HREG_ACK);
      cmd_o.take      = rd_en_i && hit(addr_i, HREG_TAKE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pol_low_o <= 1'b0;
      else if (wr_en_i && hit(addr_i, HREG_CFG))
         pol_low_o <= wr_data_i[0];
   end

   always_comb begin
      rd_mux = '0;
      if (hit(addr_i, HREG_MASK))      rd_mux = DATA_W'(mask_i);
      else if (hit(addr_i, HREG_PEEK)) rd_mux = DATA_W'(stat_i);
      else if (hit(addr_i, HREG_TAKE)) rd_mux = DATA_W'(stat_i);
      else if (hit(addr_i, HREG_CFG))  rd_mux = DATA_W'(pol_low_o);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rd_data_o <= '0;
      else if (rd_en_i) rd_data_o <= rd_mux;
      else              rd_data_o <= '0;
   end

   AST_QUIET_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en_i |=> (rd_data_o == '0)); // R6
   AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cmd_o)); // R11

endmodule

// File: rtl/hint_ctrl.sv
module hint_ctrl
   import hint_pkg::*;
#(
   parameter int unsigned        NUM_SRC  = 16,
   parameter int unsigned        ADDR_W   = 4,
   parameter int unsigned        DATA_W   = 32,
   parameter logic [NUM_SRC-1:0] MASK_RST = NUM_SRC'(1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic               wr_en_i,
   input  logic [DATA_W-1:0]  wr_data_i,
   input  logic               rd_en_i,
   output logic [DATA_W-1:0]  rd_data_o,
   output logic               irq_o
);

   if (NUM_SRC < 1 || NUM_SRC > DATA_W) begin : g_bad_src
      $error("hint_ctrl: NUM_SRC must lie in 1..DATA_W");
   end
   if (ADDR_W < HREG_AW_MIN) begin : g_bad_addr
      $error("hint_ctrl: ADDR_W too small for the register map");
   end

   hint_cmd_t          cmd;
   logic [NUM_SRC-1:0] bits, rise, stat, mask, live;
   logic [NUM_SRC-1:0] set_vec, clr_vec, ack_vec;
   logic               pol_low, pending;

   assign set_vec = cmd.mask_set ? bits : '0;
   assign clr_vec = cmd.mask_clr ? bits : '0;
   assign ack_vec = cmd.ack      ? bits : '0;

   hint_regif #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regif (
      .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_en_i(wr_en_i),
      .wr_data_i(wr_data_i), .rd_en_i(rd_en_i), .stat_i(stat), .mask_i(mask),
      .cmd_o(cmd), .bits_o(bits), .pol_low_o(pol_low), .rd_data_o(rd_data_o)
   );

   hint_edge #(.NUM_SRC(NUM_SRC)) u_edge (
      .clk(clk), .rst_n(rst_n), .src_i(src_i), .rise_o(rise)
   );

   hint_status #(.NUM_SRC(NUM_SRC)) u_status (
      .clk(clk), .rst_n(rst_n), .rise_i(rise), .ack_i(ack_vec),
      .take_i(cmd.take), .stat_o(stat)
   );

   hint_mask #(.NUM_SRC(NUM_SRC), .MASK_RST(MASK_RST)) u_mask (
      .clk(clk), .rst_n(rst_n), .load_i(cmd.mask_load), .set_i(set_vec),
      .clr_i(clr_vec), .bits_i(bits), .mask_o(mask)
   );

   assign live    = stat & ~mask;
   assign pending = |live;
   assign irq_o   = pending ^ pol_low;

   AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat & ~mask) == '0) |-> (irq_o == pol_low)); // R10
   AST_IRQ_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat & ~mask) != '0) |-> (irq_o != pol_low)); // R10

endmodule

// File: tb/tb_hint_ctrl.sv
`timescale 1ns/1ps
module tb_hint_ctrl;

   localparam real CLK_HALF = 2.5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] src = '0;
   logic [3:0]  addr = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [31:0] rd_data;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #(CLK_HALF) clk = ~clk;

   hint_ctrl dut (
      .clk(clk), .rst_n(rst_n), .src_i(src), .addr_i(addr), .wr_en_i(wr_en),
      .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_data_o(rd_data), .irq_o(irq)
   );

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   // All tasks start and end at a falling edge.
   task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
      addr = a; rd_en = 1'b1;
      exp_q.push_back(e); tag_q.push_back(tag);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse(input logic [15:0] v);
      src = v;
      @(negedge clk);
      src = '0;
   endtask

   // Monitor: pops one expected word for each read issued.
   initial begin
      forever begin
         bit fired;
         @(posedge clk);
         fired = rd_en && rst_n;
         #1;
         if (fired) begin
            check(rd_data, exp_q.pop_front(), tag_q.pop_front());
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check({31'b0, irq}, 32'h0, "R1 irq after reset");
      rd(4'd0, 32'h0000_0001, "R1 mask reset");
      rd(4'd3, 32'h0, "R1 status reset");
      rd(4'd6, 32'h0, "R1 cfg reset");

      pulse(16'h0009);
      rd(4'd3, 32'h0000_0009, "R2 masked and unmasked latch");
      check({31'b0, irq}, 32'h1, "R10 unmasked bit raises irq");
      rd(4'd3, 32'h0000_0009, "R6 peek does not clear");

      wr(4'd5, 32'h0000_0008);
      rd(4'd3, 32'h0000_0001, "R8 ack clears only written ones");
      check({31'b0, irq}, 32'h0, "R10 masked bit keeps irq low");

      src = 16'h0020;
      @(negedge clk);
      rd(4'd3, 32'h0000_0021, "R2 held source latches once");
      wr(4'd5, 32'h0000_0020);
      @(negedge clk);
      rd(4'd3, 32'h0000_0001, "R2 held high does not relatch");
      src = '0;

      rd(4'd4, 32'h0000_0001, "R7 take returns status");
      rd(4'd3, 32'h0, "R7 take cleared status");

      wr(4'd0, 32'hFFFF_00F0);
      rd(4'd0, 32'h0000_00F0, "R3 mask load");
      wr(4'd1, 32'h0000_0003);
      rd(4'd0, 32'h0000_00F3, "R4 mask set");
      wr(4'd2, 32'h0000_0030);
      rd(4'd0, 32'h0000_00C3, "R5 mask clear");

      pulse(16'h0004);
      @(negedge clk);
      src = 16'h0004;
      wr(4'd5, 32'h0000_0004);
      src = '0;
      rd(4'd3, 32'h0000_0004, "R9 event wins over ack");
      wr(4'd5, 32'h0000_0004);
      rd(4'd3, 32'h0, "R8 ack without event clears");

      pulse(16'h0004);
      src = 16'h0100;
      rd(4'd4, 32'h0000_0004, "R7 take returns old status");
      src = '0;
      rd(4'd3, 32'h0000_0100, "R9 event wins over take");

      check({31'b0, irq}, 32'h1, "R10 active high asserted");
      wr(4'd6, 32'h0000_0001);
      check({31'b0, irq}, 32'h0, "R10 active low asserted");
      rd(4'd6, 32'h0000_0001, "R10 cfg readback");
      wr(4'd5, 32'h0000_0100);
      check({31'b0, irq}, 32'h1, "R10 active low idle");
      wr(4'd6, 32'h0);
      check({31'b0, irq}, 32'h0, "R10 active high idle");

      rd(4'd1, 32'h0, "R11 mask-set reads zero");
      rd(4'd5, 32'h0, "R11 ack reads zero");
      rd(4'd7, 32'h0, "R11 unmapped reads zero");
      rd(4'd15, 32'h0, "R11 high offset reads zero");
      wr(4'd3, 32'h0000_FFFF);
      wr(4'd4, 32'h0000_FFFF);
      rd(4'd3, 32'h0, "R11 status write ignored");
      rd(4'd0, 32'h0000_00C3, "R11 mask untouched by status writes");
      check({31'b0, irq}, 32'h0, "R11 irq unchanged");

      repeat (3) @(negedge clk);
      check(32'(exp_q.size()), 32'h0, "R6 all reads answered");
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule